// File: doc/BRIEF.md
# Frequency Sweep Generator with Skipped Band

This block produces the frequency tuning word that drives a direct digital synthesizer. It ramps the word between a programmable floor and ceiling. A direction input chooses whether the word climbs toward the ceiling or descends toward the floor. When the word reaches the ceiling or the floor it stays there. Climbing and descending each have their own increment and their own dwell time between steps. The dwell time is counted in ticks of a slow synchronous enable, which fires once every `SYNC_DIV` system clocks.

A band between a low and a high jump point can be skipped. On a climb, once the word sits at or above the low jump point but below the high one, the next step puts the word exactly on the high jump point. A descent mirrors this toward the low jump point. A crossing test is used instead of an equality test, so an increment that does not divide the distance evenly still triggers the jump. The jump lands on the programmed point for every dwell setting, including dwells of one and two ticks.

Software writes the settings into shadow registers. An update strobe copies all of them into the working set at once. The same strobe can restart the sweep at the floor. It can also reload the dwell timer with a full count, so that the first dwell after the strobe is never shortened. Without that reload, the timer runs freely.

Top module: `sweep_gen`

## Requirements
- R1: The tuning word changes only on a clock edge where the synchronous tick fires, or on an update strobe. The tick fires once every `SYNC_DIV` (default 24) clocks, first on the `SYNC_DIV`-th clock after reset.
- R2: `dir_in` is sampled only at tick edges. A pulse on it that begins and ends between two ticks leaves the ramp unaffected.
- R3: With `dir_in` high, each step adds the rise increment. A result at or above the ceiling is clamped to the ceiling, including when the sum wraps past 2^W. While the word equals the ceiling, `at_upper` is 1.
- R4: With `dir_in` low, each step subtracts the fall increment. A result at or below the floor is clamped to the floor, including when the difference would go negative. While the word equals the floor, `at_lower` is 1.
- R5: The skip is active when control bit 0 is set and the low jump point is below the high jump point. On a climb, a word in [low jump, high jump) steps to the high jump point. On a descent, a word in (low jump, high jump] steps to the low jump point.
- R6: The interval register holds the climb dwell in bits [TW-1:0] and the descent dwell in bits [2*TW-1:TW], both in ticks. A dwell of 0 behaves as 1. A step fires on a tick when the timer holds 1 or less, and the timer then reloads with the dwell for the current direction.
- R7: With control bit 1 clear, an update strobe leaves the dwell timer running, so the first step after the strobe may come early.
- R8: With control bit 1 set, an update strobe loads the timer with the full new dwell for the current direction. The first step then comes on exactly the dwell-th tick after the strobe.
- R9: Writes select a register with `wr_sel`: 0 floor, 1 ceiling, 2 low jump, 3 high jump, 4 rise increment, 5 fall increment, 6 intervals, 7 control. Writes have no effect until `update`. With control bit 2 set in the shadow, `update` also loads the word with the new floor. No step is taken in the cycle of an update.
- R10: After reset, the word, all settings and the timer are 0, so `ftw` is 0 and both `at_upper` and `at_lower` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Shadow register write enable |
| wr_sel | input | 3 | Shadow register select |
| wr_data | input | W | Shadow register write data |
| update | input | 1 | Copies the shadow set into the working set |
| dir_in | input | 1 | Ramp direction, 1 climbs, 0 descends |
| ftw | output | W | Frequency tuning word |
| at_upper | output | 1 | Word equals the ceiling |
| at_lower | output | 1 | Word equals the floor |

## Verification
The monotonic and jump properties assume the working set changes only through `update`. They therefore hold only on cycles without a strobe. The bench never writes a shadow register in the same cycle as an update, and it drives every input at the falling edge, so the tick sampling sees clean levels. Skip stimulus keeps the floor below the low jump point and the high jump point below the ceiling, which is the condition under which the jump properties claim an exact landing. The direction-pulse test is placed by the bench's own tick phase so that the pulse lies strictly between ticks.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
   localparam int SEL_W       = 3;
   localparam int N_DATA_REGS = 6;

   typedef enum logic [SEL_W-1:0] {
      SEL_FLOOR    = 3'd0,
      SEL_CEIL     = 3'd1,
      SEL_JMP_LO   = 3'd2,
      SEL_JMP_HI   = 3'd3,
      SEL_INC_UP   = 3'd4,
      SEL_INC_DN   = 3'd5,
      SEL_DWELL    = 3'd6,
      SEL_CONTROL  = 3'd7
   } sweep_sel_e;

   localparam int CTL_W      = 3;
   localparam int CTL_SKIP   = 0;
   localparam int CTL_PRESET = 1;
   localparam int CTL_RELOAD = 2;
endpackage

// File: rtl/sweep_tick_gen.sv
module sweep_tick_gen #(
   parameter int DIV = 24
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

   logic [CW-1:0] cnt_q;

   generate
      if ((1 << CW) == DIV) begin : g_pow2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_q + CW'(1);
         end
         assign tick = &cnt_q;
      end else begin : g_mod
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     cnt_q <= '0;
            else if (cnt_q == CW'(DIV - 1)) cnt_q <= '0;
            else                            cnt_q <= cnt_q + CW'(1);
         end
         assign tick = (cnt_q == CW'(DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/sweep_step_timer.sv
module sweep_step_timer #(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          dir,
   input  logic [TW-1:0] dwell_up,
   input  logic [TW-1:0] dwell_dn,
   input  logic          preset,
   input  logic [TW-1:0] preset_up,
   input  logic [TW-1:0] preset_dn,
   output logic          fire,
   output logic [TW-1:0] count
);
   function automatic logic [TW-1:0] eff(input logic [TW-1:0] v);
      return (v == '0) ? TW'(1) : v;
   endfunction

   logic [TW-1:0] cnt_q;
   logic          expire;

   assign expire = (cnt_q <= TW'(1));
   assign fire   = tick & expire;
   assign count  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (preset) cnt_q <= eff(dir ? preset_up : preset_dn);
      else if (tick) begin
         if (expire) cnt_q <= eff(dir ? dwell_up : dwell_dn);
         else        cnt_q <= cnt_q - TW'(1);
      end
   end
endmodule

// File: rtl/sweep_next_calc.sv
module sweep_next_calc #(
   parameter int W = 32
) (
   input  logic [W-1:0] word,
   input  logic         dir,
   input  logic         skip_on,
   input  logic [W-1:0] floor_v,
   input  logic [W-1:0] ceil_v,
   input  logic [W-1:0] jmp_lo,
   input  logic [W-1:0] jmp_hi,
   input  logic [W-1:0] inc_up,
   input  logic [W-1:0] inc_dn,
   output logic [W-1:0] next_word
);
   logic         band_ok, in_up_band, in_dn_band;
   logic [W:0]   sum_ext, dif_ext, up_cand;
   logic [W-1:0] dn_cand;
   logic         dn_under;

   assign band_ok    = skip_on & (jmp_lo < jmp_hi);
   assign in_up_band = band_ok & (word >= jmp_lo) & (word < jmp_hi);
   assign in_dn_band = band_ok & (word > jmp_lo) & (word <= jmp_hi);
   assign sum_ext    = {1'b0, word} + {1'b0, inc_up};
   assign dif_ext    = {1'b0, word} - {1'b0, inc_dn};

   always_comb begin
      up_cand  = in_up_band ? {1'b0, jmp_hi} : sum_ext;
      dn_cand  = in_dn_band ? jmp_lo : dif_ext[W-1:0];
      dn_under = in_dn_band ? 1'b0 : dif_ext[W];
      if (dir) next_word = (up_cand >= {1'b0, ceil_v}) ? ceil_v : up_cand[W-1:0];
      else     next_word = (dn_under || dn_cand <= floor_v) ? floor_v : dn_cand;
   end
endmodule

// File: rtl/sweep_gen.sv
module sweep_gen
   import sweep_pkg::*;
#(
   parameter int W        = 32,
   parameter int TW       = 16,
   parameter int SYNC_DIV = 24,
   parameter bit HAS_SKIP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [W-1:0]     wr_data,
   input  logic             update,
   input  logic             dir_in,
   output logic [W-1:0]     ftw,
   output logic             at_upper,
   output logic             at_lower
);
   localparam int DWW = 2 * TW;

   generate
      if (W < 8)         begin : g_bad_w   $error("W must be at least 8");            end
      if (TW < 1)        begin : g_bad_tw  $error("TW must be at least 1");           end
      if (DWW > W)       begin : g_bad_dw  $error("two dwell fields must fit in W");  end
      if (SYNC_DIV < 2)  begin : g_bad_div $error("SYNC_DIV must be at least 2");     end
   endgenerate

   logic [W-1:0]     sh_data  [N_DATA_REGS];
   logic [W-1:0]     act_data [N_DATA_REGS];
   logic [DWW-1:0]   sh_dwell, act_dwell;
   logic [CTL_W-1:0] sh_ctl, act_ctl;
   logic [W-1:0]     word_q, nxt_word;
   logic             tick, fire;
   logic [TW-1:0]    tmr_cnt;
   logic             skip_on, preset_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_DATA_REGS; i++) sh_data[i] <= '0;
         sh_dwell <= '0;
         sh_ctl   <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < N_DATA_REGS; i++)
            if (wr_sel == SEL_W'(i)) sh_data[i] <= wr_data;
         if (wr_sel == SEL_DWELL)   sh_dwell <= wr_data[DWW-1:0];
         if (wr_sel == SEL_CONTROL) sh_ctl   <= wr_data[CTL_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_DATA_REGS; i++) act_data[i] <= '0;
         act_dwell <= '0;
         act_ctl   <= '0;
      end else if (update) begin
         for (int i = 0; i < N_DATA_REGS; i++) act_data[i] <= sh_data[i];
         act_dwell <= sh_dwell;
         act_ctl   <= sh_ctl;
      end
   end

   sweep_tick_gen #(.DIV(SYNC_DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   assign preset_now = update & sh_ctl[CTL_PRESET];

   sweep_step_timer #(.TW(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .dir      (dir_in),
      .dwell_up (act_dwell[TW-1:0]),
      .dwell_dn (act_dwell[DWW-1:TW]),
      .preset   (preset_now),
      .preset_up(sh_dwell[TW-1:0]),
      .preset_dn(sh_dwell[DWW-1:TW]),
      .fire     (fire),
      .count    (tmr_cnt)
   );

   assign skip_on = HAS_SKIP & act_ctl[CTL_SKIP];

   sweep_next_calc #(.W(W)) u_calc (
      .word     (word_q),
      .dir      (dir_in),
      .skip_on  (skip_on),
      .floor_v  (act_data[SEL_FLOOR]),
      .ceil_v   (act_data[SEL_CEIL]),
      .jmp_lo   (act_data[SEL_JMP_LO]),
      .jmp_hi   (act_data[SEL_JMP_HI]),
      .inc_up   (act_data[SEL_INC_UP]),
      .inc_dn   (act_data[SEL_INC_DN]),
      .next_word(nxt_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                word_q <= '0;
      else if (update && sh_ctl[CTL_RELOAD])     word_q <= sh_data[SEL_FLOOR];
      else if (fire && !update)                  word_q <= nxt_word;
   end

   assign ftw      = word_q;
   assign at_upper = (word_q == act_data[SEL_CEIL]);
   assign at_lower = (word_q == act_data[SEL_FLOOR]);
endmodule

// File: rtl/sweep_gen_chk.sv
module sweep_gen_chk #(
   parameter int W  = 32,
   parameter int TW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          update,
   input logic          dir_in,
   input logic          tick,
   input logic          fire,
   input logic [W-1:0]  ftw,
   input logic [W-1:0]  floor_a,
   input logic [W-1:0]  ceil_a,
   input logic [W-1:0]  jlo_a,
   input logic [W-1:0]  jhi_a,
   input logic          skip_on,
   input logic          reload_sh,
   input logic          preset_sh,
   input logic [W-1:0]  floor_sh,
   input logic [TW-1:0] dwell_up_sh,
   input logic [TW-1:0] tmr
);
   AST_MOVE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !update) |=> $stable(ftw)); // R1

   AST_RISE_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && dir_in && !update && ftw <= ceil_a) |=> (ftw >= $past(ftw))); // R3

   AST_FALL_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !dir_in && !update && ftw >= floor_a) |=> (ftw <= $past(ftw))); // R4

   AST_UP_JUMP_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && dir_in && !update && skip_on && ftw >= jlo_a && ftw < jhi_a && jhi_a < ceil_a)
      |=> (ftw == $past(jhi_a))); // R5

   AST_DN_JUMP_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !dir_in && !update && skip_on && ftw > jlo_a && ftw <= jhi_a && jlo_a > floor_a)
      |=> (ftw == $past(jlo_a))); // R5

   AST_PRESET_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (update && preset_sh && dir_in)
      |=> (tmr == (($past(dwell_up_sh) == '0) ? TW'(1) : $past(dwell_up_sh)))); // R8

   AST_RELOAD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (update && reload_sh) |=> (ftw == $past(floor_sh))); // R9
endmodule

bind sweep_gen sweep_gen_chk #(.W(W), .TW(TW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .update     (update),
   .dir_in     (dir_in),
   .tick       (tick),
   .fire       (fire),
   .ftw        (ftw),
   .floor_a    (act_data[0]),
   .ceil_a     (act_data[1]),
   .jlo_a      (act_data[2]),
   .jhi_a      (act_data[3]),
   .skip_on    (skip_on),
   .reload_sh  (sh_ctl[2]),
   .preset_sh  (sh_ctl[1]),
   .floor_sh   (sh_data[0]),
   .dwell_up_sh(sh_dwell[TW-1:0]),
   .tmr        (tmr_cnt)
);

// File: tb/sweep_gen_tb.sv
module sweep_gen_tb;
   localparam int W   = 32;
   localparam int TW  = 16;
   localparam int DIV = 24;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [2:0]   wr_sel = '0;
   logic [W-1:0] wr_data = '0;
   logic         update = 1'b0;
   logic         dir_in = 1'b1;
   logic [W-1:0] ftw;
   logic         at_upper, at_lower;

   int    total = 0;
   int    bad   = 0;
   string cur_req = "R10";
   bit    done  = 1'b0;

   always #4 clk = ~clk;

   sweep_gen #(.W(W), .TW(TW), .SYNC_DIV(DIV)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .update(update), .dir_in(dir_in), .ftw(ftw), .at_upper(at_upper), .at_lower(at_lower)
   );

   // behavioural reference model
   longint m_sh [8];
   longint m_act[8];
   longint m_word = 0;
   longint m_tmr  = 0;
   int     m_div  = 0;

   function automatic longint eff_dwell(longint v);
      return (v == 0) ? 1 : v;
   endfunction

   function automatic longint dwell_of(longint reg_v, bit d);
      return d ? (reg_v & 64'hFFFF) : ((reg_v >> 16) & 64'hFFFF);
   endfunction

   function automatic longint model_next(longint w, bit d);
      longint c;
      bit skip = m_act[7][0] && (m_act[2] < m_act[3]);
      if (d) begin
         if (skip && w >= m_act[2] && w < m_act[3]) c = m_act[3];
         else c = w + m_act[4];
         return (c >= m_act[1]) ? m_act[1] : c;
      end
      if (skip && w > m_act[2] && w <= m_act[3]) c = m_act[2];
      else c = w - m_act[5];
      return (c <= m_act[0]) ? m_act[0] : c;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) begin m_sh[i] = 0; m_act[i] = 0; end
         m_word = 0; m_tmr = 0; m_div = 0;
      end else begin
         bit tk, fire_m;
         tk = (m_div == DIV - 1);
         m_div = tk ? 0 : m_div + 1;
         fire_m = 1'b0;
         if (tk) begin
            if (m_tmr <= 1) begin fire_m = 1'b1; m_tmr = eff_dwell(dwell_of(m_act[6], dir_in)); end
            else m_tmr = m_tmr - 1;
         end
         if (update && m_sh[7][1]) m_tmr = eff_dwell(dwell_of(m_sh[6], dir_in));
         if (fire_m && !update) m_word = model_next(m_word, dir_in);
         if (update) begin
            for (int i = 0; i < 8; i++) m_act[i] = m_sh[i];
            if (m_sh[7][2]) m_word = m_sh[0];
         end
         if (wr_en) m_sh[wr_sel] = longint'(wr_data);
      end
   end

   // compare every clock, away from the active edge
   logic [W-1:0] prev_ftw = '0;
   bit saw_up_jump = 0, saw_dn_jump = 0, saw_odd_jump = 0;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         total++;
         if (ftw !== W'(m_word) || at_upper !== (m_word == m_act[1]) || at_lower !== (m_word == m_act[0])) begin
            bad++;
            $display("FAIL %s: ftw=%0d up=%0b lo=%0b expected ftw=%0d up=%0b lo=%0b", cur_req,
                     ftw, at_upper, at_lower, m_word, m_word == m_act[1], m_word == m_act[0]);
         end
         if (prev_ftw == 400 && ftw == 600) saw_up_jump = 1;
         if (prev_ftw == 600 && ftw == 400) saw_dn_jump = 1;
         if (prev_ftw == 450 && ftw == 600) saw_odd_jump = 1;
         prev_ftw = ftw;
      end
   end

   task automatic check(bit ok, string req, longint act, longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cycles(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(int sel, longint data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 3'(sel); wr_data = W'(data);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic strobe();
      @(negedge clk);
      update = 1'b1;
      @(negedge clk);
      update = 1'b0;
   endtask

   initial begin
      int wd = 0;
      while (!done) begin
         @(posedge clk);
         wd++;
         if (wd > 150000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", wd, 150000);
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   initial begin
      logic [W-1:0] snap;
      cycles(3);
      rst_n = 1'b1;
      cycles(1);
      // R10 reset state
      check(ftw == 0, "R10", ftw, 0);
      check(at_upper == 1, "R10", at_upper, 1);
      check(at_lower == 1, "R10", at_lower, 1);

      // R9 shadow writes have no effect before update
      cur_req = "R9";
      wr(0, 100); wr(1, 1000); wr(2, 400); wr(3, 600);
      wr(4, 50);  wr(5, 50);   wr(6, (2 << 16) | 1); wr(7, 7);
      dir_in = 1'b1;
      cycles(60);
      check(ftw == 0, "R9", ftw, 0);
      strobe();
      check(ftw == 100, "R9", ftw, 100);

      // R3 climb with skip, dwell 1
      cur_req = "R3";
      cycles(30 * DIV);
      check(ftw == 1000, "R3", ftw, 1000);
      check(at_upper == 1, "R3", at_upper, 1);
      check(saw_up_jump, "R5", saw_up_jump, 1);

      // R4 descent with skip, dwell 2
      cur_req = "R4";
      dir_in = 1'b0;
      cycles(40 * DIV);
      check(ftw == 100, "R4", ftw, 100);
      check(at_lower == 1, "R4", at_lower, 1);
      check(saw_dn_jump, "R5", saw_dn_jump, 1);

      // R6 zero dwell acts as one, uneven increment still jumps exactly
      cur_req = "R6";
      wr(4, 70); wr(6, 0); wr(7, 7);
      dir_in = 1'b1;
      strobe();
      cycles(20 * DIV);
      check(saw_odd_jump, "R6", saw_odd_jump, 1);
      check(ftw == 1000, "R6", ftw, 1000);

      // R3 overflow clamp with huge increment and top ceiling
      cur_req = "R3";
      wr(1, 64'hFFFF_FFF0); wr(4, 64'hF000_0000); wr(7, 4);
      strobe();
      cycles(4 * DIV);
      check(ftw == 32'hFFFF_FFF0, "R3", ftw, 64'hFFFF_FFF0);
      check(at_upper == 1, "R3", at_upper, 1);

      // R8 preset gives a full first dwell of 4 ticks
      cur_req = "R8";
      wr(1, 1000); wr(4, 50); wr(6, (4 << 16) | 4); wr(7, 7);
      strobe();
      snap = ftw;
      cycles(3 * DIV - 2);
      check(ftw == snap, "R8", ftw, snap);
      cycles(6 * DIV);

      // R7 free-running timer across an update without preset
      cur_req = "R7";
      wr(7, 5);
      strobe();
      cycles(10 * DIV);

      // R2 direction pulse between ticks is ignored
      cur_req = "R2";
      wr(6, (3 << 16) | 3); wr(7, 5);
      strobe();
      cycles(2 * DIV);
      while (m_div != 3) @(negedge clk);
      snap = ftw;
      dir_in = 1'b0;
      cycles(6);
      dir_in = 1'b1;
      cycles(DIV);
      check(ftw >= snap, "R2", ftw, snap);
      cycles(4 * DIV);

      // R1 a held word only moves on ticks: compare loop keeps running
      cur_req = "R1";
      cycles(3 * DIV);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule